// File: doc/BRIEF.md
# Tiled Signed Wide Multiplier

This block forms the exact two's-complement product of an 18-bit signed operand and a 22-bit signed operand. The only multiply resource it uses is a fixed 18x18 signed multiply tile, modelled behaviourally. The wide operand is cut into a narrow low slice, taken as unsigned, and an 18-bit high slice, taken as signed. Each slice is multiplied by the narrow operand in its own tile. The two partial products are then aligned and summed at full result width.

Each operand pair arrives with an input-valid strobe. Two clock cycles later the 40-bit product appears together with a result-valid strobe. The pipeline accepts a new pair on every cycle. It has two stages: the first registers the two tile outputs, and the second registers the weighted sum. The first stage also registers the narrow operand's sign, which is used only by an assertion.

Top module: `tileMulTop`

## Requirements
- R1: After synchronous reset `outValid` is 0, and it stays 0 until an input has been accepted with `inValid` high.
- R2: `outValid` is high in exactly the cycles that follow, by two clock edges, an edge at which `inValid` was high.
- R3: When `outValid` is high, `outProd` equals the exact signed product of the `opB` and `opA` that were sampled two edges earlier, over the full 40 bits with no truncation.
- R4: The low 4 bits of `opA` are used as an unsigned value from 0 to 15. The upper 18 bits are used as a signed value equal to `opA` arithmetically shifted right by 4. The high partial product carries a weight of 16.
- R5: A negative low partial product, which occurs when `opB` is negative and the low slice is nonzero, is sign-extended to 40 bits before the sum. For example, `opB` = -1 and `opA` = 1 give all ones (-1).
- R6: The pipeline accepts a new operand pair on every cycle and returns the results in the order the pairs were accepted.
- R7: The extreme pairs are exact: (-2^17, -2^21) gives +2^38, (-2^17, 2^21-1), (2^17-1, -2^21), and (2^17-1, 2^21-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand pair present |
| opB | input | 18 | Narrow signed operand |
| opA | input | 22 | Wide signed operand |
| outValid | output | 1 | Product present |
| outProd | output | 40 | Signed product |

## Verification
The bench goes after the corners where the sign handling of the split can break:
- **Negative `opB` with a small positive `opA`.** A design that zero-extends the low partial product returns a result with a cleared sign bit, giving a large positive value instead of -1.
- **The most negative values of both operands.** A sum that is too narrow, or a high slice formed by a logical shift, flips the sign of +2^38 or loses the top bits.
- **Low slices with bit 3 set.** A design that feeds the low slice to the tile as signed treats those values as negative and is off by 16 times `opB`.
- **Back-to-back random pairs.** An extra or missing pipeline stage misaligns every result against its scoreboard entry.

// File: rtl/tileMulPkg.sv
package tileMulPkg;
  localparam int TILE_W  = 18;
  localparam int B_W     = 18;
  localparam int A_W     = 22;
  localparam int LO_W    = A_W - TILE_W;
  localparam int PROD_W  = A_W + B_W;
  localparam int PP_W    = 2 * TILE_W;

  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
  } stageCtl_t;
endpackage

// File: rtl/mulTile.sv
module mulTile #(
  parameter int W = 18
) (
  input  logic signed [W-1:0]   tileX,
  input  logic signed [W-1:0]   tileY,
  output logic signed [2*W-1:0] tileP
);
  always_comb tileP = tileX * tileY;
endmodule

// File: rtl/tileMulCtrl.sv
module tileMulCtrl
  import tileMulPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output stageCtl_t ctl,
  output logic      outValid
);
  logic v1, v2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
    end
  end

  always_comb begin
    ctl.loadStage1 = inValid;
    ctl.loadStage2 = v1;
  end
  assign outValid = v2;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> !outValid);
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(inValid, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> outValid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(v1));
endmodule

// File: rtl/tileMulDatapath.sv
module tileMulDatapath
  import tileMulPkg::*;
(
  input  logic                     clk,
  input  stageCtl_t                ctl,
  input  logic signed [B_W-1:0]    opB,
  input  logic signed [A_W-1:0]    opA,
  output logic signed [PROD_W-1:0] outProd
);
  logic signed [TILE_W-1:0] hiSlice;
  logic        [LO_W-1:0]   loSlice;
  logic signed [TILE_W-1:0] loTileIn;
  logic signed [PP_W-1:0]   ppHi, ppLo;
  logic signed [PP_W-1:0]   ppHiQ, ppLoQ;
  logic                     bNegQ;
  logic signed [PROD_W-1:0] hiExt, loExt, sumW;

  always_comb begin
    hiSlice  = opA[A_W-1:LO_W];
    loSlice  = opA[LO_W-1:0];
    loTileIn = {{(TILE_W-LO_W){1'b0}}, loSlice};
  end

  mulTile #(.W(TILE_W)) uHi (.tileX(hiSlice),  .tileY(opB), .tileP(ppHi));
  mulTile #(.W(TILE_W)) uLo (.tileX(loTileIn), .tileY(opB), .tileP(ppLo));

  always_ff @(posedge clk) begin
    if (ctl.loadStage1) begin
      ppHiQ <= ppHi;
      ppLoQ <= ppLo;
      bNegQ <= opB[B_W-1];
    end
  end

  always_comb begin
    hiExt = PROD_W'(ppHiQ) <<< LO_W;
    loExt = {{(PROD_W-PP_W){ppLoQ[PP_W-1]}}, ppLoQ};
    sumW  = hiExt + loExt;
  end

  always_ff @(posedge clk) begin
    if (ctl.loadStage2) outProd <= sumW;
  end

  assert_lo_sign_R5: assert property (@(posedge clk)
    ctl.loadStage2 |-> (!bNegQ || ppLoQ[PP_W-1] || ppLoQ == '0));
endmodule

// File: rtl/tileMulTop.sv
module tileMulTop
  import tileMulPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [B_W-1:0]    opB,
  input  logic [A_W-1:0]    opA,
  output logic              outValid,
  output logic [PROD_W-1:0] outProd
);
  stageCtl_t ctl;
  tileMulCtrl u_ctrl (.clk(clk), .rst(rst), .inValid(inValid), .ctl(ctl), .outValid(outValid));
  tileMulDatapath u_dp (.clk(clk), .ctl(ctl), .opB(opB), .opA(opA), .outProd(outProd));
endmodule

// File: tb/sim_tileMulTop.sv
module sim_tileMulTop;
  logic clk = 0, rst = 1, inValid = 0;
  logic [17:0] opB = 0;
  logic [21:0] opA = 0;
  logic outValid;
  logic [39:0] outProd;
  int nChk = 0, nBad = 0;
  logic [39:0] expQ[$];
  bit done = 0;

  always #2 clk = ~clk;

  tileMulTop u0 (.clk(clk), .rst(rst), .inValid(inValid), .opB(opB), .opA(opA),
                 .outValid(outValid), .outProd(outProd));

  task automatic drive(input logic [17:0] b, input logic [21:0] a);
    logic signed [39:0] e;
    e = $signed({{22{b[17]}}, b}) * $signed({{18{a[21]}}, a});
    expQ.push_back(e);
    opB = b; opA = a; inValid = 1;
    @(posedge clk); #1;
    inValid = 0;
  endtask

  // scoreboard monitor: R2, R3, R6
  always @(negedge clk) begin
    if (!rst && outValid) begin
      nChk++;
      if (expQ.size() == 0) begin
        nBad++; $display("FAIL R2 unexpected outValid act=1 exp=0");
      end else begin
        logic [39:0] e;
        e = expQ.pop_front();
        if (outProd !== e) begin
          nBad++; $display("FAIL R3/R6 act=%h exp=%h", outProd, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    nChk++;
    if (outValid !== 0) begin nBad++; $display("FAIL R1 act=%b exp=0", outValid); end
    rst = 0;
    @(posedge clk); #1;
    nChk++;
    if (outValid !== 0) begin nBad++; $display("FAIL R1 idle act=%b exp=0", outValid); end
    drive(-18'sd1, 22'sd1);               // R5
    drive(18'h20000, 22'h200000);         // R7
    drive(18'h20000, 22'h1FFFFF);         // R7
    drive(18'h1FFFF, 22'h200000);         // R7
    drive(18'h1FFFF, 22'h1FFFFF);         // R7
    drive(-18'sd5, 22'h00000F);           // R4 low slice with bit 3 set
    drive(18'sd7, 22'h3FFFF8);            // R4
    drive(-18'sd3, 22'h123458);           // R5
    repeat (3) @(posedge clk); #1;
    for (int i = 0; i < 200; i++) drive($urandom, $urandom);  // R6 back-to-back
    repeat (4) @(posedge clk); #1;
    nChk++;
    if (expQ.size() != 0) begin nBad++; $display("FAIL R2 missing results act=%0d exp=0", expQ.size()); end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); nChk++; nBad++; $display("FAIL watchdog act=hung exp=done"); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule